// File: doc/BRIEF.md
# Keyed AFSK Tone Divider Generator

This block turns a fast, fixed reference clock into an audio-frequency shift keying square wave. The reference clock is about 5.5085 MHz. A programmable down-counter, made of cascaded 4-bit sections, is loaded with an 8-bit divisor code. Whenever it passes zero it fires a reload strobe and loads the code again, so it divides the reference by code+1. A fixed divide-by-16 stage follows it. That stage flips the audio output once every eight strobes, which gives a square wave with 50% duty.

Three divisor codes come in as configuration ports: mark, space and CW identification. The data bit chooses mark (high) or space (low). An active-low CW-ID select overrides both. The generator runs only while the active-low transmit enable is held low. A new code, from either a selection change or a code-port change, is picked up only at the next reload, so the first-stage period that is in progress is never cut short. With a mark code of 161 the output is 5.5085 MHz / 162 / 16, which is about 2125 Hz.

Top module: `afsk_tone_gen`

## Requirements
- R1: While the active-low reset `rst_n` is asserted, and on its release, `tone_out` and `reload_strobe` are 0.
- R2: While `tx_en_n` is 1, `tone_out` stays 0 and `reload_strobe` never fires. Both counters are held in their reload state, with the divider loaded with the selected code and the output stage cleared.
- R3: While enabled, with a steady selected code N (0 to 255), `reload_strobe` fires once every N+1 reference clocks. With code 0 it stays high on every cycle.
- R4: For any code N of 1 or more, `reload_strobe` is high for exactly one reference clock per reload.
- R5: `tone_out` changes level only on reload strobes, once every 8 strobes. Each half period is therefore 8×(N+1) clocks and the full period is 16×(N+1) clocks, with 50% duty.
- R6: With `cw_id_n` = 1, `data_mark` = 1 selects `mark_code` and `data_mark` = 0 selects `space_code`.
- R7: With `cw_id_n` = 0, `cwid_code` is used whatever the value of `data_mark`.
- R8: A change of the selected code takes effect only at the next reload. The reload interval already in progress keeps the length of the old code.
- R9: A mark code of 161 gives a tone period of 2592 reference clocks, which is about 2125 Hz from a 5.5085 MHz reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the divider decrements on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_n | input | 1 | Transmit enable, active low; runs the generator |
| data_mark | input | 1 | Data bit: 1 = mark, 0 = space |
| cw_id_n | input | 1 | Active-low CW identification select; overrides mark/space |
| mark_code | input | 8 | Divisor code for the mark tone |
| space_code | input | 8 | Divisor code for the space tone |
| cwid_code | input | 8 | Divisor code for the CW-ID tone |
| tone_out | output | 1 | Audio square-wave output |
| reload_strobe | output | 1 | Registered one-cycle pulse per divider reload |

## Verification
The assertions assume that the code and select inputs are synchronous to the reference clock and settle before each rising edge. They also assume that transmit enable is a level held for many cycles, not a pulse. The bench drives every input at the falling edge and samples outputs there as well. It changes codes only while the block is running, at known offsets from a sampled strobe, which keeps the R8 interval arithmetic exact. It sweeps all 256 mark codes and computes each expected interval as code+1 and each half period as 8×(code+1).

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  typedef enum logic [1:0] {
    SRC_SPACE = 2'd0,
    SRC_MARK  = 2'd1,
    SRC_CWID  = 2'd2
  } tone_src_e;

  // Source choice: CW-ID select dominates, then the data bit.
  function automatic tone_src_e pick_source(input logic data_mark, input logic cw_id_n);
    if (!cw_id_n)      return SRC_CWID;
    else if (data_mark) return SRC_MARK;
    else               return SRC_SPACE;
  endfunction

  // Reference clocks between reloads for a divisor code.
  function automatic int unsigned reload_span(input int unsigned code);
    return code + 1;
  endfunction

  // Reference clocks in one output half period.
  function automatic int unsigned half_span(input int unsigned code, input int unsigned out_div);
    return (code + 1) * (out_div / 2);
  endfunction

endpackage

// File: rtl/afsk_code_select.sv
module afsk_code_select
  import afsk_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              data_mark,
  input  logic              cw_id_n,
  input  logic [CODE_W-1:0] mark_code,
  input  logic [CODE_W-1:0] space_code,
  input  logic [CODE_W-1:0] cwid_code,
  output logic [CODE_W-1:0] sel_code,
  output tone_src_e         sel_src
);

  always_comb begin
    sel_src = pick_source(data_mark, cw_id_n);
    unique case (sel_src)
      SRC_CWID: sel_code = cwid_code;
      SRC_MARK: sel_code = mark_code;
      default:  sel_code = space_code;
    endcase
  end

endmodule

// File: rtl/afsk_reload_counter.sv
module afsk_reload_counter #(
  parameter int SECTION_W = 4,
  parameter int SECTIONS  = 2,
  localparam int CODE_W   = SECTION_W * SECTIONS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] count_o,
  output logic              borrow_o
);

  logic [SECTION_W-1:0] sect_q [SECTIONS];
  // chain[i]: every section below i is zero, so section i steps this cycle.
  logic [SECTIONS:0]    chain;
  logic                 terminal;

  assign chain[0] = 1'b1;
  assign terminal = chain[SECTIONS];

  for (genvar i = 0; i < SECTIONS; i++) begin : g_sect
    assign chain[i+1] = chain[i] && (sect_q[i] == '0);
    assign count_o[i*SECTION_W +: SECTION_W] = sect_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sect_q[i] <= '0;
      end else if (!en_i || terminal) begin
        sect_q[i] <= code_i[i*SECTION_W +: SECTION_W];
      end else if (chain[i]) begin
        sect_q[i] <= sect_q[i] - 1'b1;
      end
    end
  end

  assign borrow_o = en_i && terminal;

endmodule

// File: rtl/afsk_tone_stage.sv
module afsk_tone_stage #(
  parameter int OUT_DIV = 16,
  localparam int HALF   = OUT_DIV / 2,
  localparam int PW     = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic borrow_i,
  output logic tone_o,
  output logic flip_o
);

  localparam logic [PW-1:0] LAST = PW'(HALF - 1);

  logic [PW-1:0] cnt_q;

  assign flip_o = en_i && borrow_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tone_o <= 1'b0;
    end else if (borrow_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        tone_o <= ~tone_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/afsk_tone_gen.sv
module afsk_tone_gen
  import afsk_pkg::*;
#(
  parameter int SECTION_W = 4,
  parameter int SECTIONS  = 2,
  parameter int OUT_DIV   = 16,
  localparam int CODE_W   = SECTION_W * SECTIONS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_n,
  input  logic              data_mark,
  input  logic              cw_id_n,
  input  logic [CODE_W-1:0] mark_code,
  input  logic [CODE_W-1:0] space_code,
  input  logic [CODE_W-1:0] cwid_code,
  output logic              tone_out,
  output logic              reload_strobe
);

  // Named internal events, visible to the bound checker.
  logic              run_w;
  logic [CODE_W-1:0] sel_code_w;
  tone_src_e         sel_src_w;
  logic [CODE_W-1:0] cnt_w;
  logic              borrow_w;
  logic              flip_w;

  assign run_w = ~tx_en_n;

  afsk_code_select #(.CODE_W(CODE_W)) u_sel (
    .data_mark  (data_mark),
    .cw_id_n    (cw_id_n),
    .mark_code  (mark_code),
    .space_code (space_code),
    .cwid_code  (cwid_code),
    .sel_code   (sel_code_w),
    .sel_src    (sel_src_w)
  );

  afsk_reload_counter #(.SECTION_W(SECTION_W), .SECTIONS(SECTIONS)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (run_w),
    .code_i   (sel_code_w),
    .count_o  (cnt_w),
    .borrow_o (borrow_w)
  );

  afsk_tone_stage #(.OUT_DIV(OUT_DIV)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (run_w),
    .borrow_i (borrow_w),
    .tone_o   (tone_out),
    .flip_o   (flip_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_strobe <= 1'b0;
    else        reload_strobe <= borrow_w;
  end

endmodule

// File: rtl/afsk_checker.sv
module afsk_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en_n,
  input logic              data_mark,
  input logic              cw_id_n,
  input logic [CODE_W-1:0] mark_code,
  input logic [CODE_W-1:0] space_code,
  input logic [CODE_W-1:0] cwid_code,
  input logic [CODE_W-1:0] sel_code_w,
  input logic [CODE_W-1:0] cnt_w,
  input logic              borrow_w,
  input logic              tone_out,
  input logic              reload_strobe
);

  a_r2_quiet_tone: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_n |=> !tone_out);

  a_r2_quiet_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_n |=> !reload_strobe);

  a_r3_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_w |=> cnt_w == $past(sel_code_w));

  a_r3_down_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_n && !borrow_w) |=> cnt_w == CODE_W'($past(cnt_w) - 1'b1));

  a_r4_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reload_strobe |-> $past(cnt_w) == '0);

  a_r5_flip_on_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_n && $past(!tx_en_n) && !$past(borrow_w)) |-> $stable(tone_out));

  a_r6_mark_space: assert property (@(posedge clk) disable iff (!rst_n)
    cw_id_n |-> sel_code_w == (data_mark ? mark_code : space_code));

  a_r7_cwid_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_id_n |-> sel_code_w == cwid_code);

endmodule

bind afsk_tone_gen afsk_checker #(.CODE_W(CODE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_en_n       (tx_en_n),
  .data_mark     (data_mark),
  .cw_id_n       (cw_id_n),
  .mark_code     (mark_code),
  .space_code    (space_code),
  .cwid_code     (cwid_code),
  .sel_code_w    (sel_code_w),
  .cnt_w         (cnt_w),
  .borrow_w      (borrow_w),
  .tone_out      (tone_out),
  .reload_strobe (reload_strobe)
);

// File: tb/sim_afsk_tone_gen.sv
`timescale 1ns/1ps
module sim_afsk_tone_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en_n = 1'b1;
  logic       data_mark = 1'b1;
  logic       cw_id_n = 1'b1;
  logic [7:0] mark_code = 8'd0;
  logic [7:0] space_code = 8'd0;
  logic [7:0] cwid_code = 8'd0;
  logic       tone_out;
  logic       reload_strobe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  afsk_tone_gen u0 (
    .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .data_mark(data_mark),
    .cw_id_n(cw_id_n), .mark_code(mark_code), .space_code(space_code),
    .cwid_code(cwid_code), .tone_out(tone_out), .reload_strobe(reload_strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Negedges until the next sampled strobe.
  task automatic next_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!reload_strobe && n < 20000);
  endtask

  // Negedges until the tone level changes.
  task automatic next_flip(output int n);
    logic prev;
    prev = tone_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (tone_out == prev && n < 20000);
  endtask

  task automatic gap_for(input string req, input int exp);
    int n;
    next_strobe(n);  // realign; the reload that ends here loaded the new code
    next_strobe(n);
    check(req, n, exp);
  endtask

  task automatic tone_for(input string req, input int code);
    int n;
    int hi;
    int lo;
    mark_code = 8'(code);
    data_mark = 1'b1;
    cw_id_n   = 1'b1;
    next_flip(n);
    next_flip(n);
    next_flip(n);
    if (tone_out) begin next_flip(lo); next_flip(hi); end
    else          begin next_flip(hi); next_flip(lo); end
    check(req, hi, 8 * (code + 1));
    check(req, lo, 8 * (code + 1));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 tone in reset", tone_out, 0);
    check("R1 strobe in reset", reload_strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tone after reset", tone_out, 0);
    check("R1 strobe after reset", reload_strobe, 0);

    // R2: disabled generator stays quiet
    mark_code = 8'd3;
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (tone_out || reload_strobe) bad++;
    end
    check("R2 quiet while disabled", bad, 0);

    // R3: exhaustive sweep of mark codes
    tx_en_n = 1'b0;
    bad = 0;
    for (int c = 0; c < 256; c++) begin
      mark_code = 8'(c);
      next_strobe(n);
      next_strobe(n);
      if (n != c + 1) begin
        bad++;
        $display("FAIL R3 code %0d: actual=%0d expected=%0d", c, n, c + 1);
      end
    end
    checks++;
    if (bad != 0) errors++;
    mark_code = 8'd0;
    gap_for("R3 code 0 every cycle", 1);

    // R4: single-cycle pulse
    mark_code = 8'd1;
    next_strobe(n);
    next_strobe(n);
    @(negedge clk);
    check("R4 strobe low after pulse code 1", reload_strobe, 0);
    mark_code = 8'd9;
    next_strobe(n);
    next_strobe(n);
    @(negedge clk);
    check("R4 strobe low after pulse code 9", reload_strobe, 0);

    // R6 / R7: selection
    mark_code = 8'd20; space_code = 8'd30; cwid_code = 8'd50;
    data_mark = 1'b1; cw_id_n = 1'b1; gap_for("R6 mark", 21);
    data_mark = 1'b0; cw_id_n = 1'b1; gap_for("R6 space", 31);
    data_mark = 1'b1; cw_id_n = 1'b0; gap_for("R7 cwid over mark", 51);
    data_mark = 1'b0; cw_id_n = 1'b0; gap_for("R7 cwid over space", 51);

    // R8: mid-interval change waits for the next reload
    data_mark = 1'b1; cw_id_n = 1'b1; mark_code = 8'd10;
    next_strobe(n);
    next_strobe(n);
    repeat (3) @(negedge clk);
    mark_code = 8'd40;
    next_strobe(n);
    check("R8 interval keeps old code", n + 3, 11);
    next_strobe(n);
    check("R8 next interval uses new code", n, 41);

    // R5: half periods and duty for several codes
    tone_for("R5 code 0", 0);
    tone_for("R5 code 1", 1);
    tone_for("R5 code 5", 5);
    tone_for("R5 code 255", 255);
    // R9: mark tone
    tone_for("R9 mark 161", 161);

    // R2: re-disable clears the output
    tx_en_n = 1'b1;
    @(negedge clk);
    bad = 0;
    repeat (100) begin
      @(negedge clk);
      if (tone_out || reload_strobe) bad++;
    end
    check("R2 quiet after disable", bad, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule